// File: doc/BRIEF.md
# Core-Local Timer and Software-Interrupt Controller

This block sits beside the cores of a small multi-core processor and provides the interrupt sources that are local to each core. It keeps one free-running 64-bit time counter shared by every hart. Each hart has its own 64-bit alarm value and its own software-interrupt flag. From these it drives one machine timer-interrupt line and one machine software-interrupt line for each hart.

Software reaches the block over a plain 32-bit register bus with a valid/ready handshake. A hart's alarm is written as two 32-bit halves, and the alarm is compared again after each half is written. Another hart raises a software interrupt by writing bit 0 of the target hart's flag word. The time counter advances by one on every clock cycle in which the timebase tick input is high. The counter can be read but not written. Parameters set the hart count and the three region base addresses.

Top module: `core_timer_irq`

## Requirements
- R1: The time counter is zero after reset. It increases by one on each rising clock edge at which `tick` is high, and it holds its value otherwise.
- R2: A read of `CNT_BASE` returns counter bits 31:0 and a read of `CNT_BASE+4` returns bits 63:32. A read returns the counter value from before the accepting edge, even if `tick` is high at that edge. Writes to either word leave the counter unchanged.
- R3: Hart h owns the flag word at `SW_BASE + 4*h`. A write sets `sw_irq[h]` to bit 0 of the written data. A read returns `sw_irq[h]` in bit 0, and the other 31 bits read as zero.
- R4: Hart h owns 8 bytes of alarm at `CMP_BASE + 8*h`: bits 31:0 at offset 0 and bits 63:32 at offset 4. Writing one half replaces only that half. Either half reads back what was last stored in it.
- R5: Every alarm value is zero after reset, so every `tmr_irq` line is high once reset ends.
- R6: `tmr_irq[h]` is high exactly when alarm h is less than or equal to the counter, compared as unsigned numbers. The line rises in the same cycle in which the counter first equals the alarm, including a cycle in which an alarm write and a tick land on the same edge.
- R7: Some accesses return zero on a read and change nothing on a write. These are: an address outside the three regions, a hart index at or above `NHARTS`, and an address with bits 1:0 not zero.
- R8: `req_ready` goes high exactly one cycle after an access is accepted, which is when `req_valid` is seen high while `req_ready` is low. It stays high for one cycle, and `rsp_rdata` holds the read result while it is high.
- R9: Writing an alarm half that makes the full alarm greater than the counter drives `tmr_irq[h]` low in the cycle in which `req_ready` answers that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase tick; the counter advances on each edge at which this is high |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Registered read data |
| sw_irq | output | NHARTS | Software-interrupt line for each hart |
| tmr_irq | output | NHARTS | Timer-interrupt line for each hart |

## Verification
Two functions can land on the same clock edge: a counter tick and a bus access. The bench provokes this by raising `tick` in the cycle in which a request is presented. A counter read made that way must return the value from before the increment. In a second case, an alarm write whose value equals the counter after the increment must leave `tmr_irq` high in the completion cycle. The bench tracks the counter value itself, cycle by cycle, so it knows in advance which edge the alarm and the counter meet on.

// File: rtl/core_timer_irq.sv
module core_timer_irq #(
  parameter int          NHARTS   = 2,
  parameter int          ADDR_W   = 16,
  parameter int unsigned SW_BASE  = 32'h0000,
  parameter int unsigned CMP_BASE = 32'h4000,
  parameter int unsigned CNT_BASE = 32'hBFF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_ready,
  output logic [31:0]       rsp_rdata,
  output logic [NHARTS-1:0] sw_irq,
  output logic [NHARTS-1:0] tmr_irq
);
  localparam logic [31:0] SW_END  = 32'(SW_BASE + 4 * NHARTS);
  localparam logic [31:0] CMP_END = 32'(CMP_BASE + 8 * NHARTS);

  logic [63:0]       cnt;
  logic [63:0]       alarm [NHARTS];
  logic [NHARTS-1:0] swf;
  logic [31:0]       rd_val;

  wire [31:0] a        = 32'(req_addr);
  wire        acc      = req_valid && !req_ready;
  wire        wr       = acc && req_write;
  wire        aligned  = (a[1:0] == 2'b00);
  wire        sw_hit   = aligned && a >= SW_BASE && a < SW_END;
  wire        cmp_hit  = aligned && a >= CMP_BASE && a < CMP_END;
  wire [31:0] sw_idx   = (a - SW_BASE) >> 2;
  wire [31:0] cmp_word = (a - CMP_BASE) >> 2;
  wire [31:0] cmp_idx  = cmp_word >> 1;
  wire        cmp_hi   = cmp_word[0];

  assign sw_irq = swf;

  always_comb begin
    rd_val = '0;
    for (int h = 0; h < NHARTS; h++) begin
      if (sw_hit && sw_idx == 32'(h))   rd_val = {31'b0, swf[h]};
      if (cmp_hit && cmp_idx == 32'(h)) rd_val = cmp_hi ? alarm[h][63:32] : alarm[h][31:0];
    end
    if (a == CNT_BASE)      rd_val = cnt[31:0];
    if (a == CNT_BASE + 4)  rd_val = cnt[63:32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ready <= 1'b0;
      rsp_rdata <= '0;
      cnt       <= '0;
      swf       <= '0;
      for (int h = 0; h < NHARTS; h++) alarm[h] <= '0;
    end else begin
      req_ready <= acc;
      if (acc && !req_write) rsp_rdata <= rd_val;
      if (tick) cnt <= cnt + 64'd1;
      for (int h = 0; h < NHARTS; h++) begin
        if (wr && sw_hit && sw_idx == 32'(h)) swf[h] <= req_wdata[0];
        if (wr && cmp_hit && cmp_idx == 32'(h)) begin
          if (cmp_hi) alarm[h][63:32] <= req_wdata;
          else        alarm[h][31:0]  <= req_wdata;
        end
      end
    end
  end

  AST_READY_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> $past(req_valid)); // R8
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(cnt) + 64'd1); // R1
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt)); // R1
  AST_SW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(sw_irq)); // R3

  for (genvar h = 0; h < NHARTS; h++) begin : g_hart
    assign tmr_irq[h] = (alarm[h] <= cnt);
    AST_TMR_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmr_irq[h]) |-> ($past(tick) || $past(req_valid && req_write))); // R6
    AST_ALARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write) |=> $stable(alarm[h])); // R4
  end
endmodule

// File: tb/test_core_timer_irq.sv
`timescale 1ns/1ps
module test_core_timer_irq;
  localparam int NH = 2;
  localparam logic [15:0] SWB = 16'h0000, CMB = 16'h4000, CTB = 16'hBFF8;

  logic clk = 0, rst_n = 0, tick = 0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready;
  logic [31:0] rsp_rdata;
  logic [NH-1:0] sw_irq, tmr_irq;

  int errors = 0, checks = 0;
  longint unsigned exp_cnt = 0;
  logic [31:0] q_exp[$];
  bit          q_rd[$];
  string       q_tag[$];

  core_timer_irq #(.NHARTS(NH), .ADDR_W(16)) i_core_timer_irq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .sw_irq(sw_irq), .tmr_irq(tmr_irq));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per completion pulse
  always @(negedge clk) begin
    if (rst_n && req_ready) begin
      if (q_rd.size() == 0) chk(0, "R8 unexpected ready", 1, 0);
      else begin
        logic [31:0] e; bit r; string t;
        e = q_exp.pop_front(); r = q_rd.pop_front(); t = q_tag.pop_front();
        if (r) chk(rsp_rdata == e, t, rsp_rdata, e);
      end
    end
  end

  task automatic bus(input bit w, input logic [15:0] ad, input logic [31:0] d,
                     input logic [31:0] e, input string t, input bit tk = 0);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = ad; req_wdata = d; tick = tk;
    q_exp.push_back(e); q_rd.push_back(!w); q_tag.push_back(t);
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready latency", req_ready, 1);
    req_valid = 0; tick = 0;
    if (tk) exp_cnt++;
  endtask

  task automatic rd(input logic [15:0] ad, input logic [31:0] e, input string t, input bit tk = 0);
    bus(0, ad, 0, e, t, tk);
  endtask
  task automatic wr(input logic [15:0] ad, input logic [31:0] d, input bit tk = 0);
    bus(1, ad, d, 0, "write", tk);
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0; exp_cnt += longint'(n);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sw_irq == '0, "R3 reset sw_irq", sw_irq, 0);
    chk(tmr_irq == 2'b11, "R5 reset tmr_irq", tmr_irq, 3);
    chk(req_ready == 0, "R8 reset ready", req_ready, 0);
    rd(CTB, 0, "R1 counter reset");
    rd(CMB + 4, 0, "R5 alarm1 hi reset");
    @(negedge clk);
    chk(req_ready == 0, "R8 ready single cycle", req_ready, 0);

    run_ticks(10);
    rd(CTB, 32'(exp_cnt), "R1 R2 counter low after ticks");
    rd(CTB + 4, 0, "R2 counter high");
    wr(CTB, 32'hDEAD);
    wr(CTB + 4, 32'h5);
    rd(CTB, 32'(exp_cnt), "R2 low write ignored");
    rd(CTB + 4, 0, "R2 high write ignored");

    wr(SWB + 4, 32'hFFFF_FFFF);
    chk(sw_irq == 2'b10, "R3 set hart1", sw_irq, 2);
    rd(SWB + 4, 1, "R3 read hart1 bit0 only");
    rd(SWB, 0, "R3 read hart0");
    wr(SWB + 4, 32'h2);
    chk(sw_irq == 2'b00, "R3 clear by bit0", sw_irq, 0);

    wr(CMB, 32'd20);
    chk(tmr_irq == 2'b10, "R9 alarm0 future drops line", tmr_irq, 2);
    wr(CMB + 12, 32'h1);
    chk(tmr_irq == 2'b00, "R9 alarm1 high half", tmr_irq, 0);
    rd(CMB + 8, 0, "R4 alarm1 low kept");
    rd(CMB + 12, 1, "R4 alarm1 high stored");
    wr(CMB + 8, 32'h5);
    rd(CMB + 12, 1, "R4 high kept after low write");
    rd(CMB + 8, 5, "R4 low stored");
    rd(CMB, 20, "R4 alarm0 low");

    run_ticks(9);
    chk(tmr_irq[0] == 0, "R6 one below alarm", tmr_irq[0], 0);
    run_ticks(1);
    chk(tmr_irq[0] == 1, "R6 rises at equality", tmr_irq[0], 1);
    chk(tmr_irq[1] == 0, "R6 hart1 unsigned large", tmr_irq[1], 0);

    rd(16'h1000, 0, "R7 unmapped read");
    rd(SWB + 2, 0, "R7 misaligned read");
    rd(SWB + 8, 0, "R7 hart out of range sw");
    rd(CMB + 16, 0, "R7 hart out of range alarm");
    wr(SWB + 8, 1);
    wr(SWB + 1, 1);
    chk(sw_irq == 0, "R7 ignored sw writes", sw_irq, 0);
    wr(CMB + 14, 0);
    wr(CMB + 16, 0);
    chk(tmr_irq[1] == 0, "R7 ignored alarm writes", tmr_irq[1], 0);
    rd(CMB + 12, 1, "R7 alarm1 high untouched");

    wr(CMB, 32'(exp_cnt + 1));
    chk(tmr_irq[0] == 0, "R9 alarm0 one ahead", tmr_irq[0], 0);
    rd(CTB, 32'(exp_cnt), "R2 read with concurrent tick", 1);
    chk(tmr_irq[0] == 1, "R6 tick meets alarm", tmr_irq[0], 1);
    wr(CMB, 32'(exp_cnt + 1), 1);
    chk(tmr_irq[0] == 1, "R6 alarm write and tick same edge", tmr_irq[0], 1);
    rd(CTB, 32'(exp_cnt), "R1 counter tracked");

    repeat (3) @(negedge clk);
    chk(q_rd.size() == 0, "R8 all accesses completed", q_rd.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule